// File: doc/BRIEF.md
# Recirculating Serial Frame Transmitter

This block sends one character as an asynchronous serial frame (one start bit, eight data bits, no parity, stop level) and then keeps sending that same frame without end. The frame lives in a 13-bit ring. Every clock edge moves the ring by one position, so the clock is the bit clock. The bit that leaves the ring toward the line re-enters at the far end, which means no bit is lost and the frame repeats every 13 clocks.

Only five character bits come in on pins, and the upper three are fixed at 0,1,0. The loadable characters are therefore 0x40 to 0x5F, which covers the capital letters. A load control chooses between capturing a new character, wrapped in its start and stop bits, and letting the ring rotate. The line bit is driven in four forms: plain, inverted, gated by an enable, and gated and inverted. A tap at the far end of the ring is driven in the same four forms, so the circulating word can be watched. The enable only affects the gated outputs. The ring keeps rotating while the enable is off.

Top module: `uart_ring_tx`

## Requirements
- R1: While rst_n is low, and after it is released, the ring holds all ones until the first load. ser_o and tap_o are 1, and ser_n_o and tap_n_o are 0.
- R2: A clock edge with load_i=1 captures a frame. On the following cycles ser_o shows, one bit per clock: 0 (start), then char_i[0], char_i[1], char_i[2], char_i[3], char_i[4], 0, 1, 0, then 1,1,1,1.
- R3: While load_i=0, the frame on ser_o repeats with a period of exactly 13 clocks, and the number of ones in the frame never changes.
- R4: While load_i=0, tap_o in a cycle equals ser_o from the cycle before. The bit that leaves toward the line re-enters at the far end of the ring.
- R5: ser_n_o is always the inverse of ser_o, and tap_n_o is always the inverse of tap_o.
- R6: With en_i=1, ser_gated_o equals ser_o and ser_gated_n_o equals ser_n_o. With en_i=0, ser_gated_o is 1 and ser_gated_n_o is 0.
- R7: en_i has no effect on the ring. After any stretch with en_i=0, the frame on ser_o continues in the same phase as if the enable had stayed on.
- R8: The tap outputs follow the same gating rule: with en_i=0, tap_gated_o is 1 and tap_gated_n_o is 0. With en_i=1 they equal tap_o and tap_n_o.
- R9: A load in the middle of a frame replaces the ring at once. The next cycle shows the new start bit, whatever phase the old frame was in.
- R10: While load_i is held at 1 on consecutive edges, ser_o stays 0 (the start bit) and tap_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| load_i | input | 1 | 1: capture a new frame; 0: rotate the ring |
| char_i | input | 5 | Low five bits of the character |
| en_i | input | 1 | Enable for the gated outputs |
| ser_o | output | 1 | Line bit, plain |
| ser_n_o | output | 1 | Line bit, inverted |
| ser_gated_o | output | 1 | Line bit, gated, idles at 1 |
| ser_gated_n_o | output | 1 | Line bit, inverted and gated, idles at 0 |
| tap_o | output | 1 | Far-end ring bit, plain |
| tap_n_o | output | 1 | Far-end ring bit, inverted |
| tap_gated_o | output | 1 | Far-end ring bit, gated, idles at 1 |
| tap_gated_n_o | output | 1 | Far-end ring bit, inverted and gated, idles at 0 |

## Verification
The bench targets several specific failure modes:
- A frame whose bit order is reversed, or whose fixed upper bits are wrong, gives a different serial character. Directed loads of 0x40, 0x5F and 0x41 expose this bit by bit.
- A ring that shifts instead of rotating loses its ones and stops repeating. The check on the second and third passes of each frame catches this.
- A design that freezes the ring while the enable is off comes back out of phase.
- Gated outputs that idle at the wrong level, a load that waits for a frame boundary, and a reset that leaves zeros in the ring all show up as mismatches against the bench's own frame model.

// File: rtl/uart_ring_pkg.sv
package uart_ring_pkg;
  parameter int unsigned FRAME_W = 13;
  parameter int unsigned CHAR_W  = 8;
  parameter int unsigned LOAD_W  = 5;
  localparam int unsigned FIX_W  = CHAR_W - LOAD_W;
  localparam int unsigned STOP_W = FRAME_W - 1 - CHAR_W;
  parameter logic [FIX_W-1:0] FIXED_HI = 3'b010;

  typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/uart_frame_builder.sv
module uart_frame_builder
  import uart_ring_pkg::*;
(
  input  logic [LOAD_W-1:0] char_i,
  output frame_t            frame_o
);
  logic [CHAR_W-1:0] full_char;

  always_comb begin
    full_char = {FIXED_HI, char_i};
    // bit 0 leaves first: start, data LSB first, then stop/idle ones
    frame_o = {{STOP_W{1'b1}}, full_char, 1'b0};
  end
endmodule

// File: rtl/uart_ring_shifter.sv
module uart_ring_shifter
  import uart_ring_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  frame_t frame_i,
  output frame_t ring_o
);
  frame_t ring_q;
  frame_t ring_d;

  always_comb begin
    if (load_i) ring_d = frame_i;
    else        ring_d = {ring_q[0], ring_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '1;
    else        ring_q <= ring_d;
  end

  assign ring_o = ring_q;

  // R3: rotation conserves the number of ones in the ring
  p_ones_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($countones(ring_q) == $countones($past(ring_q))));

  // R1: the reset image is all ones
  p_reset_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ring_q == '1));
endmodule

// File: rtl/uart_line_driver.sv
module uart_line_driver (
  input  logic bit_i,
  input  logic en_i,
  output logic plain_o,
  output logic inv_o,
  output logic gated_o,
  output logic gated_inv_o
);
  always_comb begin
    plain_o     = bit_i;
    inv_o       = ~bit_i;
    gated_o     = en_i ? bit_i  : 1'b1;
    gated_inv_o = en_i ? ~bit_i : 1'b0;
  end
endmodule

// File: rtl/uart_ring_tx.sv
module uart_ring_tx
  import uart_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LOAD_W-1:0] char_i,
  input  logic              en_i,
  output logic              ser_o,
  output logic              ser_n_o,
  output logic              ser_gated_o,
  output logic              ser_gated_n_o,
  output logic              tap_o,
  output logic              tap_n_o,
  output logic              tap_gated_o,
  output logic              tap_gated_n_o
);
  localparam int unsigned N_DRV = 2;

  frame_t           new_frame;
  frame_t           ring;
  logic [N_DRV-1:0] drv_bit;
  logic [N_DRV-1:0] drv_plain;
  logic [N_DRV-1:0] drv_inv;
  logic [N_DRV-1:0] drv_gated;
  logic [N_DRV-1:0] drv_gated_inv;

  uart_frame_builder u_build (
    .char_i  (char_i),
    .frame_o (new_frame)
  );

  uart_ring_shifter u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .frame_i (new_frame),
    .ring_o  (ring)
  );

  assign drv_bit[0] = ring[0];
  assign drv_bit[1] = ring[FRAME_W-1];

  for (genvar g = 0; g < N_DRV; g++) begin : g_drv
    uart_line_driver u_drv (
      .bit_i       (drv_bit[g]),
      .en_i        (en_i),
      .plain_o     (drv_plain[g]),
      .inv_o       (drv_inv[g]),
      .gated_o     (drv_gated[g]),
      .gated_inv_o (drv_gated_inv[g])
    );
  end

  assign ser_o         = drv_plain[0];
  assign ser_n_o       = drv_inv[0];
  assign ser_gated_o   = drv_gated[0];
  assign ser_gated_n_o = drv_gated_inv[0];
  assign tap_o         = drv_plain[1];
  assign tap_n_o       = drv_inv[1];
  assign tap_gated_o   = drv_gated[1];
  assign tap_gated_n_o = drv_gated_inv[1];

  // R4: the far end receives the bit that just left toward the line
  p_tap_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (tap_o == $past(ser_o)));

  // R2: a load puts the start bit on the line and idle at the far end
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!ser_o && tap_o));

  // R6 / R8: both gated pairs idle together when disabled
  p_gate_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (ser_gated_o && tap_gated_o && !ser_gated_n_o && !tap_gated_n_o));

  // R5: inverted pins of both drivers stay complementary
  p_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_o != ser_n_o) && (tap_o != tap_n_o));
endmodule

// File: tb/uart_ring_tx_tb.sv
module uart_ring_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i;
  logic [4:0] char_i;
  logic       en_i;
  logic ser_o, ser_n_o, ser_gated_o, ser_gated_n_o;
  logic tap_o, tap_n_o, tap_gated_o, tap_gated_n_o;

  int checks = 0;
  int fails  = 0;
  logic [12:0] model;

  always #4 clk = ~clk;

  uart_ring_tx u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .char_i(char_i), .en_i(en_i),
    .ser_o(ser_o), .ser_n_o(ser_n_o), .ser_gated_o(ser_gated_o),
    .ser_gated_n_o(ser_gated_n_o), .tap_o(tap_o), .tap_n_o(tap_n_o),
    .tap_gated_o(tap_gated_o), .tap_gated_n_o(tap_gated_n_o)
  );

  function automatic logic [12:0] frame_of(input logic [4:0] c);
    return {4'b1111, 3'b010, c, 1'b0};
  endfunction

  function automatic logic [12:0] rot(input logic [12:0] r);
    return {r[0], r[12:1]};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R2/R3 ser_o", ser_o, model[0]);
    chk("R4 tap_o", tap_o, model[12]);
    chk("R5 ser_n_o", ser_n_o, ~model[0]);
    chk("R5 tap_n_o", tap_n_o, ~model[12]);
    chk("R6 ser_gated_o", ser_gated_o, en_i ? model[0] : 1'b1);
    chk("R6 ser_gated_n_o", ser_gated_n_o, en_i ? ~model[0] : 1'b0);
    chk("R8 tap_gated_o", tap_gated_o, en_i ? model[12] : 1'b1);
    chk("R8 tap_gated_n_o", tap_gated_n_o, en_i ? ~model[12] : 1'b0);
  endtask

  // called at negedge: drive, take an edge, update model, check at next negedge
  task automatic cyc(input logic ld, input logic [4:0] c, input logic en);
    load_i = ld; char_i = c; en_i = en;
    @(posedge clk);
    model = ld ? frame_of(c) : rot(model);
    @(negedge clk);
    chk_all();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [12:0] captured;
    seed = $urandom(32'd7171);
    rst_n = 1'b0; load_i = 1'b0; char_i = '0; en_i = 1'b1;
    model = '1;
    repeat (2) @(negedge clk);
    chk_all(); // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < 15; i++) cyc(1'b0, 5'h0, 1'b1); // R1 idles high, R3 on ones

    // R2: explicit bit order for 'A' (0x41)
    cyc(1'b1, 5'h01, 1'b1);
    begin
      logic [12:0] exp_seq;
      exp_seq = 13'b1111_010_00001_0;
      chk("R2 start bit", ser_o, exp_seq[0]);
      for (int i = 1; i < 13; i++) begin
        cyc(1'b0, 5'h0, 1'b1);
        chk("R2 ordered bit", ser_o, exp_seq[i]);
      end
    end
    // R3: period of 13, two more passes
    for (int i = 0; i < 26; i++) cyc(1'b0, 5'h0, 1'b1);

    // corner characters 0x40 and 0x5F
    cyc(1'b1, 5'h00, 1'b1);
    for (int i = 0; i < 13; i++) cyc(1'b0, 5'h0, 1'b1);
    cyc(1'b1, 5'h1F, 1'b1);
    for (int i = 0; i < 13; i++) cyc(1'b0, 5'h0, 1'b1);

    // R7: disable for 20 cycles, phase kept
    for (int i = 0; i < 20; i++) cyc(1'b0, 5'h0, 1'b0);
    for (int i = 0; i < 13; i++) cyc(1'b0, 5'h0, 1'b1);

    // R9: load mid-frame
    cyc(1'b1, 5'h0A, 1'b1);
    repeat (4) cyc(1'b0, 5'h0, 1'b1);
    cyc(1'b1, 5'h15, 1'b1);
    chk("R9 new start bit", ser_o, 1'b0);

    // R10: hold load
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 5'h1A, 1'b1);
      chk("R10 held start", ser_o, 1'b0);
      chk("R10 held tap", tap_o, 1'b1);
    end

    // R3: frame repeats identically after 13 cycles
    cyc(1'b1, 5'h13, 1'b1);
    captured = '0;
    for (int i = 0; i < 13; i++) begin captured[i] = ser_o; cyc(1'b0, 5'h0, 1'b1); end
    for (int i = 0; i < 13; i++) begin
      chk("R3 repeat", ser_o, captured[i]);
      cyc(1'b0, 5'h0, 1'b1);
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic ld, en;
      ld = ($urandom % 10) == 0;
      en = ($urandom % 4) != 0;
      cyc(ld, 5'($urandom), en);
    end

    // R1: asynchronous reset mid-frame
    cyc(1'b1, 5'h02, 1'b1);
    #1 rst_n = 1'b0;
    #1;
    model = '1;
    chk("R1 async clear ser", ser_o, 1'b1);
    chk("R1 async clear tap", tap_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++) cyc(1'b0, 5'h0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule